// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

This block collects interrupt events, holds them in a pending register and gates them with a software-written enable register. Every internal interrupt line is assigned at build time to one priority level and to a trigger type, edge or level. From the eligible lines (pending and enabled), the controller finds the highest level that lies strictly above the processor's current interrupt level. It reports that level and raises an interrupt request to the core.

Events arrive one per cycle on a small event port. Each event carries a line number, an active/inactive flag and a selector that says whether the number is internal or external. External numbers are translated to internal indices through a build-time table. Numbers outside the configured range are dropped.

A level-type line loses its pending bit when its source deasserts. An edge-type line keeps its pending bit until software clears it through a mask-based clear port, and that port never touches level-type bits. Vectoring and exception entry belong to the core and are not part of this block.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the pending and enable registers are all zero, so `pendLevel` is 0 and `cpuIrq` is low even when every line is then enabled.
- R2: An event with `sigValid`=1, `sigExt`=0, `sigActive`=1 and `sigNum` < NUM_IRQ sets pending bit `sigNum`.
- R3: An inactive event (`sigActive`=0) clears the addressed pending bit only when that line is level-type. A line is edge-type when bit i of the EDGE_MASK parameter is 1. An edge-type bit stays set.
- R4: When `clrValid`=1, every pending bit whose `clrMask` bit is 1 and which is edge-type is cleared, and level-type bits are left alone. If an active event sets a bit in the same cycle, the set wins.
- R5: `enWe`=1 loads `enData` into the enable register. Only lines that are both pending and enabled take part in priority resolution.
- R6: Line i belongs to the level held in IRQ_LEVEL[i*LVL_W +: LVL_W], where levels run from 1 to NUM_LEVELS. `pendLevel` is the highest level L > `curLevel` that holds an eligible line, and `cpuIrq` is then high.
- R7: When no level above `curLevel` holds an eligible line, `pendLevel` is 0 and `cpuIrq` is low.
- R8: An internal event whose `sigNum` ≥ NUM_IRQ changes no pending bit.
- R9: An event with `sigExt`=1 addresses internal line EXT_MAP[e*IDX_W +: IDX_W], where e is `sigNum`, and then behaves as in R2 and R3. An external number e ≥ NUM_EXT changes nothing.
- R10: A change of pending or enable bits shows at the outputs in the cycle after the clock edge that stores it. A change of `curLevel` shows without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigValid | input | 1 | Event strobe |
| sigExt | input | 1 | 1: `sigNum` is an external number, 0: internal index |
| sigNum | input | NUM_W | Line number of the event |
| sigActive | input | 1 | 1: source asserted, 0: source deasserted |
| clrValid | input | 1 | Software clear strobe |
| clrMask | input | NUM_IRQ | Lines to clear (edge-type only) |
| enWe | input | 1 | Enable register write strobe |
| enData | input | NUM_IRQ | New enable register value |
| curLevel | input | LVL_W | Current interrupt level of the core |
| pendLevel | output | LVL_W | Highest pending level above `curLevel`, 0 when none |
| cpuIrq | output | 1 | Interrupt request to the core |

## Verification
The bench uses the default build: eight internal lines over three levels, three of them edge-type, four external numbers, and a 4-bit event number. With that build, internal numbers 8 to 15 and external numbers 4 to 15 can be driven, so both rejection paths are exercised. The small size also allows a full sweep: every one of the 256 enable patterns is tried against every current level from 0 to 3, for several pending patterns. Individual pending bits are read back by enabling one line at a time and observing the reported level.

// File: rtl/lic_pkg.sv
package lic_pkg;

  // Strobes passed from the event decoder to the state datapath
  typedef struct packed {
    logic setHit;   // addressed line goes pending
    logic dropHit;  // addressed level-type line leaves pending
    logic clrHit;   // software clear of edge-type lines
    logic enHit;    // enable register load
  } licStrobes_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int NUM_EXT = 4,
  parameter int NUM_W   = 4,
  parameter int IDX_W   = 3,
  parameter logic [NUM_IRQ-1:0]       EDGE_MASK = '0,
  parameter logic [NUM_EXT*IDX_W-1:0] EXT_MAP   = '0
) (
  input  logic             sigValid,
  input  logic             sigExt,
  input  logic [NUM_W-1:0] sigNum,
  input  logic             sigActive,
  input  logic             clrValid,
  input  logic             enWe,
  output licStrobes_t      strobes,
  output logic [IDX_W-1:0] tgtIdx
);

  localparam logic [NUM_W-1:0] IRQ_LIM = NUM_W'(NUM_IRQ);
  localparam logic [NUM_W-1:0] EXT_LIM = NUM_W'(NUM_EXT);

  logic inRange;
  logic isEdge;

  // Resolve the event number to an internal index, rejecting out-of-range numbers
  always_comb begin
    inRange = 1'b0;
    tgtIdx  = '0;
    if (sigExt) begin
      if (sigNum < EXT_LIM) begin
        inRange = 1'b1;
        for (int e = 0; e < NUM_EXT; e++) begin
          if (sigNum == NUM_W'(e)) tgtIdx = EXT_MAP[e*IDX_W +: IDX_W];
        end
      end
    end else if (sigNum < IRQ_LIM) begin
      inRange = 1'b1;
      tgtIdx  = sigNum[IDX_W-1:0];
    end
  end

  // Trigger type of the addressed line
  always_comb begin
    isEdge = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (tgtIdx == IDX_W'(i)) isEdge = EDGE_MASK[i];
    end
  end

  always_comb begin
    strobes.setHit  = sigValid & inRange & sigActive;
    strobes.dropHit = sigValid & inRange & ~sigActive & ~isEdge;
    strobes.clrHit  = clrValid;
    strobes.enHit   = enWe;
  end

endmodule

// File: rtl/lic_state.sv
module lic_state
  import lic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = 3,
  parameter logic [NUM_IRQ-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  licStrobes_t        strobes,
  input  logic [IDX_W-1:0]   tgtIdx,
  input  logic [NUM_IRQ-1:0] clrMask,
  input  logic [NUM_IRQ-1:0] enData,
  output logic [NUM_IRQ-1:0] pendQ,
  output logic [NUM_IRQ-1:0] enQ
);

  logic [NUM_IRQ-1:0] setVec;
  logic [NUM_IRQ-1:0] dropVec;
  logic [NUM_IRQ-1:0] clrVec;
  logic [NUM_IRQ-1:0] pendD;

  // One-hot expansion of the addressed line
  always_comb begin
    setVec  = '0;
    dropVec = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (tgtIdx == IDX_W'(i)) begin
        setVec[i]  = strobes.setHit;
        dropVec[i] = strobes.dropHit;
      end
    end
  end

  // Software clear reaches edge-type lines only; a set in the same cycle wins
  assign clrVec = strobes.clrHit ? (clrMask & EDGE_MASK) : '0;
  assign pendD  = (pendQ & ~dropVec & ~clrVec) | setVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      enQ   <= '0;
    end else begin
      pendQ <= pendD;
      if (strobes.enHit) enQ <= enData;
    end
  end

endmodule

// File: rtl/lic_resolve.sv
module lic_resolve #(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_LEVELS = 3,
  parameter int LVL_W      = 2,
  parameter logic [NUM_IRQ*LVL_W-1:0] IRQ_LEVEL = '0
) (
  input  logic [NUM_IRQ-1:0] pendQ,
  input  logic [NUM_IRQ-1:0] enQ,
  input  logic [LVL_W-1:0]   curLevel,
  output logic [LVL_W-1:0]   pendLevel,
  output logic               cpuIrq
);

  logic [NUM_IRQ-1:0]    eligible;
  logic [NUM_IRQ-1:0]    levelMask [1:NUM_LEVELS];
  logic [NUM_LEVELS:1]   levelHit;

  assign eligible = pendQ & enQ;

  // Per-level membership masks and qualification against the current level
  for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
      assign levelMask[l][i] = (IRQ_LEVEL[i*LVL_W +: LVL_W] == LVL_W'(l));
    end
    assign levelHit[l] = (|(levelMask[l] & eligible)) && (LVL_W'(l) > curLevel);
  end

  // Scan from the top level down; the first qualifying level is reported
  always_comb begin
    pendLevel = '0;
    for (int l = NUM_LEVELS; l >= 1; l--) begin
      if (levelHit[l] && (pendLevel == '0)) pendLevel = LVL_W'(l);
    end
  end

  assign cpuIrq = |levelHit;

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
  import lic_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_EXT    = 4,
  parameter int NUM_LEVELS = 3,
  localparam int LVL_W = $clog2(NUM_LEVELS + 1),
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int NUM_W = $clog2(maxOf(NUM_IRQ, NUM_EXT) + 1),
  parameter logic [NUM_IRQ*LVL_W-1:0] IRQ_LEVEL = 16'h9FA5,
  parameter logic [NUM_IRQ-1:0]       EDGE_MASK = 8'hA4,
  parameter logic [NUM_EXT*IDX_W-1:0] EXT_MAP   = 12'h1EA
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sigValid,
  input  logic               sigExt,
  input  logic [NUM_W-1:0]   sigNum,
  input  logic               sigActive,
  input  logic               clrValid,
  input  logic [NUM_IRQ-1:0] clrMask,
  input  logic               enWe,
  input  logic [NUM_IRQ-1:0] enData,
  input  logic [LVL_W-1:0]   curLevel,
  output logic [LVL_W-1:0]   pendLevel,
  output logic               cpuIrq
);

  licStrobes_t        strobes;
  logic [IDX_W-1:0]   tgtIdx;
  logic [NUM_IRQ-1:0] pendQ;
  logic [NUM_IRQ-1:0] enQ;

  lic_decode #(
    .NUM_IRQ(NUM_IRQ), .NUM_EXT(NUM_EXT), .NUM_W(NUM_W), .IDX_W(IDX_W),
    .EDGE_MASK(EDGE_MASK), .EXT_MAP(EXT_MAP)
  ) u_decode (
    .sigValid(sigValid), .sigExt(sigExt), .sigNum(sigNum), .sigActive(sigActive),
    .clrValid(clrValid), .enWe(enWe), .strobes(strobes), .tgtIdx(tgtIdx)
  );

  lic_state #(
    .NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W), .EDGE_MASK(EDGE_MASK)
  ) u_state (
    .clk(clk), .rstN(rstN), .strobes(strobes), .tgtIdx(tgtIdx),
    .clrMask(clrMask), .enData(enData), .pendQ(pendQ), .enQ(enQ)
  );

  lic_resolve #(
    .NUM_IRQ(NUM_IRQ), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .IRQ_LEVEL(IRQ_LEVEL)
  ) u_resolve (
    .pendQ(pendQ), .enQ(enQ), .curLevel(curLevel),
    .pendLevel(pendLevel), .cpuIrq(cpuIrq)
  );

endmodule

// File: rtl/lic_check.sv
module lic_check
  import lic_pkg::*;
#(
  parameter int NUM_IRQ    = 8,
  parameter int NUM_EXT    = 4,
  parameter int NUM_LEVELS = 3,
  localparam int LVL_W = $clog2(NUM_LEVELS + 1),
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int NUM_W = $clog2(maxOf(NUM_IRQ, NUM_EXT) + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               sigValid,
  input logic               sigExt,
  input logic [NUM_W-1:0]   sigNum,
  input logic               sigActive,
  input logic               clrValid,
  input logic [LVL_W-1:0]   curLevel,
  input logic [LVL_W-1:0]   pendLevel,
  input logic               cpuIrq,
  input logic [NUM_IRQ-1:0] pendQ
);

  localparam logic [NUM_W-1:0] IRQ_LIM = NUM_W'(NUM_IRQ);
  localparam logic [NUM_W-1:0] EXT_LIM = NUM_W'(NUM_EXT);
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_LEVELS);

  // R1
  reset_clear_chk: assert property (@(posedge clk) $rose(rstN) |-> (pendQ == '0));

  // R7
  irq_flag_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (pendLevel != '0));

  // R6
  level_above_cur_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq |-> ((pendLevel > curLevel) && (pendLevel <= TOP_LVL)));

  // R2
  set_on_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && !sigExt && sigActive && (sigNum < IRQ_LIM))
      |=> pendQ[$past(sigNum[IDX_W-1:0])]);

  // R8
  oor_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && !sigExt && (sigNum >= IRQ_LIM) && !clrValid) |=> $stable(pendQ));

  // R9
  ext_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && sigExt && (sigNum >= EXT_LIM) && !clrValid) |=> $stable(pendQ));

endmodule

bind lvl_irq_ctrl lic_check #(
  .NUM_IRQ(NUM_IRQ), .NUM_EXT(NUM_EXT), .NUM_LEVELS(NUM_LEVELS)
) chk (
  .clk(clk), .rstN(rstN), .sigValid(sigValid), .sigExt(sigExt), .sigNum(sigNum),
  .sigActive(sigActive), .clrValid(clrValid), .curLevel(curLevel),
  .pendLevel(pendLevel), .cpuIrq(cpuIrq), .pendQ(pendQ)
);

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;

  localparam int NIRQ = 8;
  localparam int NEXT = 4;
  localparam int NLVL = 3;
  localparam logic [15:0] LVL_TAB  = 16'h9FA5;
  localparam logic [7:0]  EDGE_TAB = 8'hA4;
  localparam logic [11:0] MAP_TAB  = 12'h1EA;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sigValid = 1'b0, sigExt = 1'b0, sigActive = 1'b0;
  logic [3:0] sigNum = '0;
  logic       clrValid = 1'b0, enWe = 1'b0;
  logic [7:0] clrMask = '0, enData = '0;
  logic [1:0] curLevel = '0;
  logic [1:0] pendLevel;
  logic       cpuIrq;

  int checks = 0;
  int fails = 0;
  logic [7:0] model = '0;

  always #5 clk = ~clk;

  lvl_irq_ctrl #(
    .NUM_IRQ(NIRQ), .NUM_EXT(NEXT), .NUM_LEVELS(NLVL),
    .IRQ_LEVEL(LVL_TAB), .EDGE_MASK(EDGE_TAB), .EXT_MAP(MAP_TAB)
  ) uut (
    .clk(clk), .rstN(rstN), .sigValid(sigValid), .sigExt(sigExt), .sigNum(sigNum),
    .sigActive(sigActive), .clrValid(clrValid), .clrMask(clrMask), .enWe(enWe),
    .enData(enData), .curLevel(curLevel), .pendLevel(pendLevel), .cpuIrq(cpuIrq)
  );

  function automatic int lvlOf(input int i);
    return int'(LVL_TAB[i*2 +: 2]);
  endfunction

  function automatic int mapOf(input int e);
    return int'(MAP_TAB[e*3 +: 3]);
  endfunction

  function automatic int expLevel(input logic [7:0] p, input logic [7:0] e, input int cl);
    int best = 0;
    for (int i = 0; i < NIRQ; i++)
      if (p[i] && e[i] && lvlOf(i) > cl && lvlOf(i) > best) best = lvlOf(i);
    return best;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendEvt(input bit ext, input int num, input bit act);
    sigValid = 1'b1; sigExt = ext; sigNum = 4'(num); sigActive = act;
    @(posedge clk); @(negedge clk);
    sigValid = 1'b0;
  endtask

  task automatic doClr(input logic [7:0] m);
    clrValid = 1'b1; clrMask = m;
    @(posedge clk); @(negedge clk);
    clrValid = 1'b0;
  endtask

  task automatic writeEn(input logic [7:0] v);
    enWe = 1'b1; enData = v;
    @(posedge clk); @(negedge clk);
    enWe = 1'b0;
  endtask

  // Read back each pending bit by enabling one line at a time
  task automatic sweepBits(input string req);
    for (int i = 0; i < NIRQ; i++) begin
      writeEn(8'(1 << i));
      curLevel = 2'd0;
      #1;
      check(req, int'(pendLevel), model[i] ? lvlOf(i) : 0);
      check(req, int'(cpuIrq), int'(model[i]));
    end
  endtask

  // Every enable pattern against every current level
  task automatic sweepAll(input string req);
    for (int e = 0; e < 256; e++) begin
      writeEn(8'(e));
      for (int cl = 0; cl < 4; cl++) begin
        int x;
        curLevel = 2'(cl);
        #1;
        x = expLevel(model, 8'(e), cl);
        check(req, int'(pendLevel), x);
        check(req, int'(cpuIrq), int'(x != 0));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1", int'(pendLevel), 0);
    check("R1", int'(cpuIrq), 0);
    writeEn(8'hFF);
    #1;
    check("R1", int'(pendLevel), 0);

    // R10 timing: nothing before the edge, level after it
    sigValid = 1'b1; sigExt = 1'b0; sigNum = 4'd4; sigActive = 1'b1;
    #1;
    check("R10", int'(pendLevel), 0);
    @(posedge clk); @(negedge clk);
    sigValid = 1'b0;
    model[4] = 1'b1;
    #1;
    check("R10", int'(pendLevel), 3);
    curLevel = 2'd3;
    #1;
    check("R10", int'(pendLevel), 0);
    check("R10", int'(cpuIrq), 0);
    curLevel = 2'd0;

    // R2 set every internal line
    for (int i = 0; i < NIRQ; i++) sendEvt(1'b0, i, 1'b1);
    model = 8'hFF;
    sweepBits("R2");

    // R3 deassert all: only level-type bits drop
    for (int i = 0; i < NIRQ; i++) sendEvt(1'b0, i, 1'b0);
    model = model & EDGE_TAB;
    sweepBits("R3");

    // R8 internal numbers out of range
    for (int n = NIRQ; n < 16; n++) sendEvt(1'b0, n, 1'b1);
    sweepBits("R8");

    // R4 software clear
    for (int i = 0; i < NIRQ; i++) sendEvt(1'b0, i, 1'b1);
    model = 8'hFF;
    doClr(8'hFF);
    model = 8'hFF & ~EDGE_TAB;
    sweepBits("R4");
    // R4 set and clear of the same edge line in one cycle: set wins
    clrValid = 1'b1; clrMask = 8'hFF;
    sigValid = 1'b1; sigExt = 1'b0; sigNum = 4'd2; sigActive = 1'b1;
    @(posedge clk); @(negedge clk);
    clrValid = 1'b0; sigValid = 1'b0;
    model[2] = 1'b1;
    sweepBits("R4");

    // Empty the pending register, then R7 with nothing pending
    for (int i = 0; i < NIRQ; i++) sendEvt(1'b0, i, 1'b0);
    doClr(8'hFF);
    model = '0;
    sweepAll("R7");

    // R9 external numbers, in range and rejected
    for (int e = 0; e < 16; e++) begin
      sendEvt(1'b1, e, 1'b1);
      if (e < NEXT) model[mapOf(e)] = 1'b1;
    end
    sweepBits("R9");
    sendEvt(1'b1, 3, 1'b0);
    model[mapOf(3)] = EDGE_TAB[mapOf(3)] ? model[mapOf(3)] : 1'b0;
    sendEvt(1'b1, 0, 1'b0);
    model[mapOf(0)] = EDGE_TAB[mapOf(0)] ? model[mapOf(0)] : 1'b0;
    sweepBits("R9");

    // R5 and R6 full sweeps on two pending patterns
    sweepAll("R6");
    for (int i = 0; i < NIRQ; i++) sendEvt(1'b0, i, 1'b1);
    model = 8'hFF;
    sweepAll("R5");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule